// File: doc/BRIEF.md
# Capture-Offset Compare Timer

This block is an 8-bit free-running up-counter with a capture path and two compare channels. An asynchronous external strobe is brought into the clock domain. Each rising edge of that strobe copies the live count into a private capture register. The bus cannot read or write the capture register.

The first compare channel, the offset channel, fires whenever the count equals the captured value plus a programmable offset. That sum wraps modulo 256. The channel is held quiet in two cycles: the cycle in which the offset is being written, and the cycle in which a capture lands. This keeps a half-updated target from producing a false match.

The second compare channel, the pin channel, matches the count against a fixed constant register. A 2-bit action field decides what that match does to a single output pin: keep it, clear it, set it or toggle it.

Software sets the offset, the constant and the action field through a write-only register port with a 2-bit address. The counter advances only while the count-enable input is high.

Top module: `cap_ofs_timer`

## Requirements
- R1: After reset the count is 0, the pin output is 0, the offset register holds 0xFF, the constant register holds 0xFF, the action field holds 00 and the capture register holds 0.
- R2: On each clock edge with `cnt_en` high the count rises by one and wraps from 0xFF to 0x00. With `cnt_en` low the count holds.
- R3: `ext_rst` passes through two synchroniser flops, and a rising edge is detected on the synchronised signal. In the cycle where that edge is detected, the next clock edge copies the present count into the capture register. A falling edge or a steady level captures nothing.
- R4: `match_c` is high, combinationally, in every cycle where the count equals the 8-bit sum of the offset register and the capture register, unless R6 or R7 applies.
- R5: The offset-plus-capture sum wraps modulo 256. For example, capture 0xF0 plus offset 0x20 matches at count 0x10.
- R6: `match_c` is low in any cycle where `wr_en` is high with `wr_addr` = 0, the offset address.
- R7: `match_c` is low in the cycle in which a capture is taking place.
- R8: `match_a` is high, combinationally, whenever the count equals the constant register. The constant register is written at `wr_addr` = 1.
- R9: The action field is written at `wr_addr` = 2 from `wr_data[1:0]`. On the clock edge that ends a cycle with `match_a` high, the pin responds to the field: 00 keeps its value, 01 goes to 0, 10 goes to 1 and 11 inverts. Without a match the pin holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count enable |
| ext_rst | input | 1 | Asynchronous capture strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 offset, 1 constant, 2 action field |
| wr_data | input | 8 | Write data |
| cnt_o | output | 8 | Current count |
| match_a | output | 1 | Constant-compare match |
| match_c | output | 1 | Offset-compare match |
| pin_out | output | 1 | Controlled output pin |

## Verification
The offset channel is first exercised with the counter frozen, so that each capture latches a known value. Frozen captures of 0 and 0x37 show that the latched count really drives the target and that a falling strobe edge latches nothing. A repeat capture of an unchanged value, and a rewrite of an unchanged offset, each cost exactly one low cycle on an otherwise steady match; this isolates the two blanking rules from any real change of target. A free-running sweep with capture 0xF0 and offset 0x20 tells a wrapping sum apart from a saturating or widened one. The pin is then driven through all four action codes in turn, starting from a pin level at which each code's effect is visible.

// File: rtl/cot_pkg.sv
package cot_pkg;
   typedef enum logic [1:0] {
      PIN_KEEP   = 2'b00,
      PIN_LOW    = 2'b01,
      PIN_HIGH   = 2'b10,
      PIN_TOGGLE = 2'b11
   } pin_act_e;

   localparam int ADDR_W      = 2;
   localparam int ADDR_OFFSET = 0;
   localparam int ADDR_CONST  = 1;
   localparam int ADDR_ACTION = 2;
endpackage

// File: rtl/cot_edge_sync.sv
module cot_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              last_q;

   if (STAGES < 2) begin : g_chk
      $fatal(1, "cot_edge_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) chain[0] <= 1'b0;
      else        chain[0] <= din;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) chain[i] <= 1'b0;
         else        chain[i] <= chain[i-1];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/cot_count_cap.sv
module cot_count_cap #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cnt_en,
   input  logic         cap_evt,
   output logic [W-1:0] cnt,
   output logic [W-1:0] cap
);
   localparam logic [W-1:0] ONE = W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt <= '0;
      else if (cnt_en) cnt <= cnt + ONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       cap <= '0;
      else if (cap_evt) cap <= cnt;
   end
endmodule

// File: rtl/cot_regs.sv
module cot_regs
   import cot_pkg::*;
#(
   parameter int W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [W-1:0]      wr_data,
   output logic [W-1:0]      ofs_q,
   output logic [W-1:0]      const_q,
   output pin_act_e          act_q,
   output logic              ofs_wr
);
   logic const_wr, act_wr;

   assign ofs_wr   = wr_en && (wr_addr == ADDR_W'(ADDR_OFFSET));
   assign const_wr = wr_en && (wr_addr == ADDR_W'(ADDR_CONST));
   assign act_wr   = wr_en && (wr_addr == ADDR_W'(ADDR_ACTION));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ofs_q   <= '1;
         const_q <= '1;
         act_q   <= PIN_KEEP;
      end else begin
         if (ofs_wr)   ofs_q   <= wr_data;
         if (const_wr) const_q <= wr_data;
         if (act_wr)   act_q   <= pin_act_e'(wr_data[1:0]);
      end
   end
endmodule

// File: rtl/cot_pin.sv
module cot_pin
   import cot_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     hit,
   input  pin_act_e act,
   output logic     pin
);
   logic pin_nx;

   always_comb begin
      pin_nx = pin;
      if (hit) begin
         unique case (act)
            PIN_KEEP:   pin_nx = pin;
            PIN_LOW:    pin_nx = 1'b0;
            PIN_HIGH:   pin_nx = 1'b1;
            PIN_TOGGLE: pin_nx = ~pin;
            default:    pin_nx = pin;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pin <= 1'b0;
      else        pin <= pin_nx;
   end
endmodule

// File: rtl/cap_ofs_timer.sv
module cap_ofs_timer
   import cot_pkg::*;
#(
   parameter int W           = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_en,
   input  logic              ext_rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [W-1:0]      wr_data,
   output logic [W-1:0]      cnt_o,
   output logic              match_a,
   output logic              match_c,
   output logic              pin_out
);
   logic [W-1:0] cnt, cap_val, ofs_q, const_q, target;
   logic         cap_evt, ofs_wr;
   pin_act_e     act_q;

   if (W < 2) begin : g_chk
      $fatal(1, "cap_ofs_timer: W must be at least 2");
   end

   cot_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .din(ext_rst), .rise(cap_evt)
   );

   cot_count_cap #(.W(W)) cc_i (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cap_evt(cap_evt),
      .cnt(cnt), .cap(cap_val)
   );

   cot_regs #(.W(W)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .ofs_q(ofs_q), .const_q(const_q),
      .act_q(act_q), .ofs_wr(ofs_wr)
   );

   // width-limited add: carry out is dropped, so the target wraps
   assign target  = cap_val + ofs_q;
   assign match_c = (cnt == target) && !ofs_wr && !cap_evt;
   assign match_a = (cnt == const_q);
   assign cnt_o   = cnt;

   cot_pin pin_i (
      .clk(clk), .rst_n(rst_n), .hit(match_a), .act(act_q), .pin(pin_out)
   );
endmodule

// File: rtl/cap_ofs_timer_chk.sv
module cap_ofs_timer_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         cnt_en,
   input logic [W-1:0] cnt,
   input logic [W-1:0] cap_val,
   input logic         cap_evt,
   input logic         ofs_wr,
   input logic         match_a,
   input logic         match_c,
   input logic [1:0]   act_q,
   input logic         pin_out
);
   a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_en |=> cnt == W'($past(cnt) + W'(1)));
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_en |=> $stable(cnt));
   a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> cap_val == $past(cnt));
   a_r3_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_evt |=> $stable(cap_val));
   a_r6_write_blank: assert property (@(posedge clk) disable iff (!rst_n)
      ofs_wr |-> !match_c);
   a_r7_capture_blank: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |-> !match_c);
   a_r9_set: assert property (@(posedge clk) disable iff (!rst_n)
      (match_a && act_q == 2'b10) |=> pin_out);
   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (match_a && act_q == 2'b01) |=> !pin_out);
   a_r9_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (match_a && act_q == 2'b11) |=> pin_out != $past(pin_out));
   a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!match_a || act_q == 2'b00) |=> $stable(pin_out));
endmodule

bind cap_ofs_timer cap_ofs_timer_chk #(.W(W)) chk_i (
   .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt(cnt), .cap_val(cap_val),
   .cap_evt(cap_evt), .ofs_wr(ofs_wr), .match_a(match_a),
   .match_c(match_c), .act_q(act_q), .pin_out(pin_out)
);

// File: tb/cap_ofs_timer_tb_top.sv
module cap_ofs_timer_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cnt_en = 1'b0, ext_rst = 1'b0, wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic [7:0] cnt_o;
   logic       match_a, match_c, pin_out;
   int         n_run = 0, n_fail = 0;

   always #2 clk = ~clk;

   cap_ofs_timer dut_i (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .ext_rst(ext_rst),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .cnt_o(cnt_o),
      .match_a(match_a), .match_c(match_c), .pin_out(pin_out)
   );

   task automatic check(string req, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic write_reg(logic [1:0] a, logic [7:0] d);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic advance(int n);
      @(posedge clk); #1;
      cnt_en = 1'b1;
      repeat (n) @(posedge clk);
      #1 cnt_en = 1'b0;
   endtask

   // raise the strobe, hold it, drop it, and let the synchroniser settle
   task automatic strobe(output int low_cycles);
      low_cycles = 0;
      @(posedge clk); #1 ext_rst = 1'b1;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (!match_c) low_cycles++;
      end
      @(posedge clk); #1 ext_rst = 1'b0;
      repeat (6) @(posedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1 count", cnt_o, 0);
      check("R1 pin", pin_out, 0);
      check("R1 match_a", match_a, 0);
      check("R1 match_c", match_c, 0);
      advance(255);
      @(negedge clk);
      check("R1 offset FF target", match_c, 1);
      check("R8 constant FF", match_a, 1);
      advance(1);
      @(negedge clk);
      check("R2 wrap", cnt_o, 0);
   endtask

   task automatic t_count();
      int start;
      @(negedge clk); start = cnt_o;
      repeat (5) @(posedge clk);
      @(negedge clk);
      check("R2 hold", cnt_o, start);
      advance(19);
      @(negedge clk);
      check("R2 step", cnt_o, (start + 19) % 256);
   endtask

   task automatic t_capture();
      int lows;
      write_reg(2'd0, 8'h00);
      advance(256 - cnt_o);
      @(negedge clk);
      check("R4 frozen match at capture 0", match_c, 1);
      advance(8'h37);
      @(negedge clk);
      check("R4 no match before capture", match_c, 0);
      strobe(lows);
      @(negedge clk);
      check("R3 capture 0x37", match_c, 1);
      strobe(lows);
      check("R7 one blanked cycle", lows, 1);
      @(negedge clk);
      check("R3 falling edge keeps capture", match_c, 1);
   endtask

   task automatic t_write_blank();
      @(posedge clk); #1;
      wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h00;
      @(negedge clk);
      check("R6 blank during offset write", match_c, 0);
      @(posedge clk); #1 wr_en = 1'b0;
      @(negedge clk);
      check("R6 match back after write", match_c, 1);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h00;
      @(negedge clk);
      check("R6 other address not blanked", match_c, 1);
      @(posedge clk); #1 wr_en = 1'b0;
   endtask

   task automatic t_wrap_sum();
      int lows, bad = 0, hits = 0;
      advance((8'hF0 - cnt_o + 256) % 256);
      strobe(lows);
      write_reg(2'd0, 8'h20);
      @(posedge clk); #1 cnt_en = 1'b1;
      for (int i = 0; i < 512; i++) begin
         @(negedge clk);
         if (match_c != (cnt_o == 8'h10)) bad++;
         if (match_c) hits++;
      end
      @(posedge clk); #1 cnt_en = 1'b0;
      check("R5 wrapped target mismatches", bad, 0);
      check("R5 wrapped target hits", hits, 2);
   endtask

   task automatic wait_match();
      int guard = 0;
      @(negedge clk);
      while (match_a) begin @(negedge clk); guard++; end
      while (!match_a && guard < 600) begin @(negedge clk); guard++; end
      @(negedge clk);
   endtask

   task automatic t_pin();
      int moved = 0;
      write_reg(2'd1, 8'h05);
      write_reg(2'd2, 8'h02);
      @(posedge clk); #1 cnt_en = 1'b1;
      wait_match();
      check("R9 action 10 sets", pin_out, 1);
      write_reg(2'd2, 8'h03);
      wait_match();
      check("R9 action 11 toggles to 0", pin_out, 0);
      wait_match();
      check("R9 action 11 toggles to 1", pin_out, 1);
      write_reg(2'd2, 8'h00);
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (!pin_out) moved++;
      end
      check("R9 action 00 keeps", moved, 0);
      write_reg(2'd2, 8'h01);
      wait_match();
      check("R9 action 01 clears", pin_out, 0);
      @(posedge clk); #1 cnt_en = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_count();
      t_capture();
      t_write_blank();
      t_wrap_sum();
      t_pin();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #400000;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule